// File: doc/BRIEF.md
# Precision-Split SIMD Arithmetic Lane

This block is a packed-integer arithmetic lane for a vector engine. It is built from 32-bit slices, and the number of slices is a parameter (1, 2 or 4). Each slice holds one set of byte-wide adders and one array of 8x8 partial-product multipliers. Those circuits serve byte, halfword and word elements alike. The carry between byte adders is gated at element edges. Partial products that would cross an element are forced to zero before the remaining ones are combined.

Every cycle the lane accepts one operation. It takes two packed operands, a packed accumulator, an opcode and a size code.

- Add and subtract return after one cycle, together with per-element carry or borrow flags.
- Multiply and multiply-accumulate return after two cycles.

Each path has its own valid strobe and its own result register, so an add and a multiply issued one cycle apart both finish in the same cycle.

Top module: `psimd_lane`

## Requirements
- R1: After reset, addValid and mulValid are 0, and addResult, addFlags and mulResult are all zero.
- R2: An accepted add or subtract (inValid=1 with opcode 0=add or 1=subtract) raises addValid exactly one clock later, with its result in addResult.
- R3: With sizeCode 0 (byte), each 8-bit element is added on its own, modulo 256. No carry passes bit 8, 16 or 24 of any slice.
- R4: With sizeCode 1 (halfword), each 16-bit element is added modulo 65536. The carry is blocked at bit 16 of each slice.
- R5: With sizeCode 2 (word), each 32-bit slice is one element modulo 2^32, and no carry passes from one slice into the next.
- R6: Subtract (opcode 1) gives opA minus opB per element, wrapping modulo the element width.
- R7: addFlags holds one bit per byte of the operand. For each element, the bit at the element's most significant byte is the carry out (for add) or the borrow (for subtract, set when opA < opB unsigned). Every other bit of addFlags is 0.
- R8: An accepted multiply (opcode 2) or multiply-accumulate (opcode 3) raises mulValid exactly two clocks later, with its result in mulResult.
- R9: Multiply returns, per element, the low element-width bits of the unsigned product of the opA and opB elements, at byte, halfword and word sizes.
- R10: Multiply-accumulate returns, per element, acc plus the product of opA and opB, modulo the element width.
- R11: addResult and addFlags change only when addValid is 1. mulResult changes only when mulValid is 1. A multiply leaves the add outputs unchanged.
- R12: sizeCode 3 behaves exactly as sizeCode 2 (word).
- R13: A multiply followed in the next cycle by an add completes both correctly in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An operation is presented this cycle |
| opcode | input | 2 | 0 add, 1 subtract, 2 multiply, 3 multiply-accumulate |
| sizeCode | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| opA | input | 32*NUM_SLICES | First packed operand |
| opB | input | 32*NUM_SLICES | Second packed operand |
| acc | input | 32*NUM_SLICES | Packed accumulator for multiply-accumulate |
| addValid | output | 1 | addResult and addFlags were updated this cycle |
| addResult | output | 32*NUM_SLICES | Packed add or subtract result |
| addFlags | output | 4*NUM_SLICES | Per-element carry or borrow, at each element's top byte |
| mulValid | output | 1 | mulResult was updated this cycle |
| mulResult | output | 32*NUM_SLICES | Packed multiply or multiply-accumulate result |

## Verification
The hardest case to reach is a carry that arrives exactly at a gated edge. The gate at an element edge must stop it, and the word carry at the edge between two slices must stop as well. Random data seldom produces such a carry, so the stimulus uses all-ones elements plus one, placed next to elements that must stay untouched. Each result is compared with a per-element model computed in the bench. The other hard case is both pipelines finishing in the same cycle. The bench issues a multiply and then, on the very next clock, an add, and checks both outputs in the cycle where they meet.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
  typedef enum logic [1:0] {OP_ADD = 2'd0, OP_SUB = 2'd1, OP_MUL = 2'd2, OP_MAC = 2'd3} opE;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WIDE = 2'd3} sizeE;

  // control strobes handed to the datapath
  typedef struct packed {
    logic addGo;
    logic subMode;
    logic mulGo;
    logic macMode;
    logic byteMode;
    logic halfMode;
  } strobeT;
endpackage

// File: rtl/psimd_ctrl.sv
module psimd_ctrl
  import psimd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] opcode,
  input  logic [1:0] sizeCode,
  output strobeT     stS0,
  output strobeT     stS1,
  output logic       addValid,
  output logic       mulValid
);
  always_comb begin
    stS0.addGo    = inValid && (opcode == OP_ADD || opcode == OP_SUB);
    stS0.subMode  = (opcode == OP_SUB);
    stS0.mulGo    = inValid && (opcode == OP_MUL || opcode == OP_MAC);
    stS0.macMode  = (opcode == OP_MAC);
    stS0.byteMode = (sizeCode == SZ_BYTE);
    stS0.halfMode = (sizeCode == SZ_HALF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stS1     <= '0;
      addValid <= 1'b0;
      mulValid <= 1'b0;
    end else begin
      stS1     <= stS0;
      addValid <= stS0.addGo;
      mulValid <= stS1.mulGo;
    end
  end
endmodule

// File: rtl/psimd_slice.sv
module psimd_slice
  import psimd_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobeT         stS0,
  input  strobeT         stS1,
  input  logic [SW-1:0]  a,
  input  logic [SW-1:0]  b,
  input  logic [SW-1:0]  c,
  output logic [SW-1:0]  addRes,
  output logic [SW/8-1:0] addFlg,
  output logic [SW-1:0]  mulRes
);
  localparam int NBY = SW / 8;
  localparam int NHW = NBY / 2;

  // byte-wide adders chained through gated carries
  function automatic logic [NBY+SW-1:0] gatedAdd(input logic [SW-1:0] x, input logic [SW-1:0] y,
                                                 input logic sub, input logic byteM, input logic halfM);
    logic [SW-1:0]  s;
    logic [NBY-1:0] f;
    logic           cy;
    logic [8:0]     t;
    logic [7:0]     yb;
    cy = 1'b0;
    s  = '0;
    f  = '0;
    for (int k = 0; k < NBY; k++) begin
      yb = sub ? ~y[k*8 +: 8] : y[k*8 +: 8];
      if (k == 0 || byteM || (halfM && (k % 2 == 0))) cy = sub;
      t = {1'b0, x[k*8 +: 8]} + {1'b0, yb} + {8'b0, cy};
      s[k*8 +: 8] = t[7:0];
      cy = t[8];
      f[k] = (k == NBY-1 || byteM || (halfM && (k % 2 == 1))) ? (cy ^ sub) : 1'b0;
    end
    return {f, s};
  endfunction

  logic [NBY+SW-1:0] addComb;
  always_comb addComb = gatedAdd(a, b, stS0.subMode, stS0.byteMode, stS0.halfMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addRes <= '0;
      addFlg <= '0;
    end else if (stS0.addGo) begin
      addRes <= addComb[SW-1:0];
      addFlg <= addComb[NBY+SW-1:SW];
    end
  end

  // shared partial-product array, gated by element membership
  logic [15:0] ppD [NBY][NBY];
  logic [15:0] ppQ [NBY][NBY];
  logic [SW-1:0] accQ;

  always_comb begin
    for (int i = 0; i < NBY; i++) begin
      for (int j = 0; j < NBY; j++) begin
        logic keep;
        if (stS0.byteMode)      keep = (i == j);
        else if (stS0.halfMode) keep = ((i / 2) == (j / 2));
        else                    keep = ((i + j) < NBY);
        ppD[i][j] = keep ? ({8'b0, a[i*8 +: 8]} * {8'b0, b[j*8 +: 8]}) : 16'h0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      for (int i = 0; i < NBY; i++)
        for (int j = 0; j < NBY; j++)
          ppQ[i][j] <= 16'h0;
    end else if (stS0.mulGo) begin
      accQ <= c;
      for (int i = 0; i < NBY; i++)
        for (int j = 0; j < NBY; j++)
          ppQ[i][j] <= ppD[i][j];
    end
  end

  // combine partial products per precision, then accumulate
  logic [SW-1:0] prodB, prodH, prodW, prodSel;
  logic [NBY+SW-1:0] macComb;

  always_comb begin
    prodB = '0;
    prodH = '0;
    prodW = '0;
    for (int k = 0; k < NBY; k++) prodB[k*8 +: 8] = ppQ[k][k][7:0];
    for (int h = 0; h < NHW; h++) begin
      prodH[h*16 +: 16] = ppQ[2*h][2*h]
                        + {ppQ[2*h+1][2*h][7:0], 8'h00}
                        + {ppQ[2*h][2*h+1][7:0], 8'h00};
    end
    for (int i = 0; i < NBY; i++)
      for (int j = 0; j < NBY; j++)
        if ((i + j) < NBY) prodW = prodW + (SW'(ppQ[i][j]) << (8 * (i + j)));
    if (stS1.byteMode)      prodSel = prodB;
    else if (stS1.halfMode) prodSel = prodH;
    else                    prodSel = prodW;
    macComb = gatedAdd(prodSel, accQ, 1'b0, stS1.byteMode, stS1.halfMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            mulRes <= '0;
    else if (stS1.mulGo)  mulRes <= stS1.macMode ? macComb[SW-1:0] : prodSel;
  end
endmodule

// File: rtl/psimd_datapath.sv
module psimd_datapath
  import psimd_pkg::*;
#(
  parameter int NUM_SLICES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobeT                  stS0,
  input  strobeT                  stS1,
  input  logic [32*NUM_SLICES-1:0] opA,
  input  logic [32*NUM_SLICES-1:0] opB,
  input  logic [32*NUM_SLICES-1:0] acc,
  output logic [32*NUM_SLICES-1:0] addResult,
  output logic [4*NUM_SLICES-1:0]  addFlags,
  output logic [32*NUM_SLICES-1:0] mulResult
);
  localparam int SW  = 32;
  localparam int NBY = SW / 8;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : gSlice
    psimd_slice #(.SW(SW)) uSlice (
      .clk    (clk),
      .rstN   (rstN),
      .stS0   (stS0),
      .stS1   (stS1),
      .a      (opA[s*SW +: SW]),
      .b      (opB[s*SW +: SW]),
      .c      (acc[s*SW +: SW]),
      .addRes (addResult[s*SW +: SW]),
      .addFlg (addFlags[s*NBY +: NBY]),
      .mulRes (mulResult[s*SW +: SW])
    );
  end
endmodule

// File: rtl/psimd_lane.sv
module psimd_lane
  import psimd_pkg::*;
#(
  parameter int NUM_SLICES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [1:0]               opcode,
  input  logic [1:0]               sizeCode,
  input  logic [32*NUM_SLICES-1:0] opA,
  input  logic [32*NUM_SLICES-1:0] opB,
  input  logic [32*NUM_SLICES-1:0] acc,
  output logic                     addValid,
  output logic [32*NUM_SLICES-1:0] addResult,
  output logic [4*NUM_SLICES-1:0]  addFlags,
  output logic                     mulValid,
  output logic [32*NUM_SLICES-1:0] mulResult
);
  strobeT stS0, stS1;

  psimd_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (opcode),
    .sizeCode (sizeCode),
    .stS0     (stS0),
    .stS1     (stS1),
    .addValid (addValid),
    .mulValid (mulValid)
  );

  psimd_datapath #(.NUM_SLICES(NUM_SLICES)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stS0      (stS0),
    .stS1      (stS1),
    .opA       (opA),
    .opB       (opB),
    .acc       (acc),
    .addResult (addResult),
    .addFlags  (addFlags),
    .mulResult (mulResult)
  );
endmodule

// File: rtl/psimd_lane_chk.sv
module psimd_lane_chk #(
  parameter int NUM_SLICES = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic [1:0]               opcode,
  input logic [1:0]               sizeCode,
  input logic                     addValid,
  input logic [32*NUM_SLICES-1:0] addResult,
  input logic [4*NUM_SLICES-1:0]  addFlags,
  input logic                     mulValid,
  input logic [32*NUM_SLICES-1:0] mulResult
);
  localparam int NB = 4 * NUM_SLICES;

  function automatic logic [NB-1:0] nonTop(input int per);
    logic [NB-1:0] m;
    m = '0;
    for (int k = 0; k < NB; k++) if ((k % per) != per - 1) m[k] = 1'b1;
    return m;
  endfunction

  localparam logic [NB-1:0] HALF_OFF = nonTop(2);
  localparam logic [NB-1:0] WORD_OFF = nonTop(4);

  // R2
  a_r2_add_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opcode[1]) |=> addValid);

  // R8
  a_r8_mul_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode[1]) |=> ##1 mulValid);

  // R11
  a_r11_add_hold: assert property (@(posedge clk) disable iff (!rstN)
    !addValid |-> ($stable(addResult) && $stable(addFlags)));

  a_r11_mul_hold: assert property (@(posedge clk) disable iff (!rstN)
    !mulValid |-> $stable(mulResult));

  // R7
  a_r7_half_flag_pos: assert property (@(posedge clk) disable iff (!rstN)
    (addValid && $past(sizeCode) == 2'd1) |-> ((addFlags & HALF_OFF) == '0));

  a_r7_word_flag_pos: assert property (@(posedge clk) disable iff (!rstN)
    (addValid && $past(sizeCode[1])) |-> ((addFlags & WORD_OFF) == '0));
endmodule

bind psimd_lane psimd_lane_chk #(.NUM_SLICES(NUM_SLICES)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .opcode    (opcode),
  .sizeCode  (sizeCode),
  .addValid  (addValid),
  .addResult (addResult),
  .addFlags  (addFlags),
  .mulValid  (mulValid),
  .mulResult (mulResult)
);

// File: tb/sim_psimd_lane.sv
`timescale 1ns/1ps
module sim_psimd_lane;
  localparam int NS = 2;
  localparam int W  = 32 * NS;
  localparam int NB = 4 * NS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] opcode = 2'd0;
  logic [1:0] sizeCode = 2'd0;
  logic [W-1:0] opA = '0, opB = '0, acc = '0;
  logic addValid, mulValid;
  logic [W-1:0] addResult, mulResult;
  logic [NB-1:0] addFlags;

  int numChecks = 0;
  int numFails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  psimd_lane #(.NUM_SLICES(NS)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .sizeCode(sizeCode),
    .opA(opA), .opB(opB), .acc(acc), .addValid(addValid), .addResult(addResult),
    .addFlags(addFlags), .mulValid(mulValid), .mulResult(mulResult)
  );

  task automatic finishRun();
    $display("%0d/%0d checks passed", numChecks - numFails, numChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      numChecks++;
      numFails++;
      $display("FAIL watchdog: run hung act=%0d exp<20000", cycles);
      finishRun();
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-element reference model
  function automatic logic [W-1:0] refRes(input int op, input int sz, input logic [W-1:0] a,
                                          input logic [W-1:0] b, input logic [W-1:0] c,
                                          output logic [NB-1:0] flg);
    int ew, ne;
    longint unsigned m, ea, eb, ec, r;
    logic [W-1:0] res;
    logic fl;
    ew = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    ne = W / ew;
    m  = (64'h1 << ew) - 1;
    res = '0;
    flg = '0;
    for (int e = 0; e < ne; e++) begin
      ea = 64'(a >> (e * ew)) & m;
      eb = 64'(b >> (e * ew)) & m;
      ec = 64'(c >> (e * ew)) & m;
      fl = 1'b0;
      case (op)
        0: begin r = ea + eb; fl = r[ew]; end
        1: begin r = ea - eb; fl = (ea < eb); end
        2: r = ea * eb;
        default: r = ec + ea * eb;
      endcase
      res = res | (W'(r & m) << (e * ew));
      if (op < 2) flg[e * (ew / 8) + ew / 8 - 1] = fl;
    end
    return res;
  endfunction

  task automatic runOp(input string req, input int op, input int sz,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
    logic [NB-1:0] ef;
    logic [W-1:0] er;
    er = refRes(op, sz, a, b, c, ef);
    @(negedge clk);
    inValid = 1'b1; opcode = 2'(op); sizeCode = 2'(sz); opA = a; opB = b; acc = c;
    @(negedge clk);
    inValid = 1'b0;
    if (op < 2) begin
      check({req, " addValid"}, W'(addValid), W'(1));
      check({req, " addResult"}, addResult, er);
      check({req, " addFlags"}, W'(addFlags), W'(ef));
    end else begin
      check({req, " mulValid early"}, W'(mulValid), W'(0));
      @(negedge clk);
      check({req, " mulValid"}, W'(mulValid), W'(1));
      check({req, " mulResult"}, mulResult, er);
    end
  endtask

  task automatic testReset();
    check("R1 addValid", W'(addValid), '0);
    check("R1 mulValid", W'(mulValid), '0);
    check("R1 addResult", addResult, '0);
    check("R1 addFlags", W'(addFlags), '0);
    check("R1 mulResult", mulResult, '0);
  endtask

  task automatic testAdds();
    runOp("R2 R3 R7 byte add", 0, 0, 64'hFF80_7F01_FFFF_0102, 64'h0180_0101_0001_FF03, '0);
    runOp("R4 R7 half add", 0, 1, 64'hFFFF_8000_1234_FFFF, 64'h0001_8000_EDCC_0001, '0);
    runOp("R5 R7 word add", 0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, '0);
    runOp("R5 word add no carry", 0, 2, 64'h1234_5678_7FFF_FFFF, 64'h1111_1111_0000_0001, '0);
  endtask

  task automatic testSubs();
    runOp("R6 R7 byte sub", 1, 0, 64'h0010_FF00_0180_7F05, 64'h0110_00FF_0280_8006, '0);
    runOp("R6 R7 half sub", 1, 1, 64'h0000_8000_1234_0001, 64'h0001_7FFF_1234_0002, '0);
    runOp("R6 R7 word sub", 1, 2, 64'h0000_0000_8000_0000, 64'h0000_0001_7FFF_FFFF, '0);
  endtask

  task automatic testMuls();
    runOp("R8 R9 byte mul", 2, 0, 64'hFF10_0302_8011_FFFE, 64'hFF10_0504_0211_FF03, '0);
    runOp("R9 half mul", 2, 1, 64'hFFFF_1234_0100_8001, 64'hFFFF_0002_0100_0003, '0);
    runOp("R9 word mul", 2, 2, 64'hFFFF_FFFF_1234_5678, 64'h0000_0003_9ABC_DEF0, '0);
  endtask

  task automatic testMacs();
    runOp("R10 byte mac", 3, 0, 64'h0202_0F10_FF01_0304, 64'h0303_1110_FF01_0506, 64'hFF01_0280_0102_FFF0);
    runOp("R10 half mac", 3, 1, 64'h0100_FFFF_1234_0002, 64'h0100_0002_0010_8000, 64'h0001_0003_FFFF_1234);
    runOp("R10 word mac", 3, 2, 64'hFFFF_FFFF_0001_0000, 64'h0000_0002_0001_0000, 64'h0000_0005_FFFF_FFFF);
  endtask

  task automatic testWide();
    runOp("R12 size3 add", 0, 3, 64'hFFFF_FFFF_00FF_00FF, 64'h0000_0001_0001_0001, '0);
    runOp("R12 size3 mul", 2, 3, 64'h0001_0001_0000_0101, 64'h0001_0001_0000_0101, '0);
  endtask

  task automatic testHold();
    logic [W-1:0] ar, mr;
    logic [NB-1:0] af;
    runOp("R11 setup add", 0, 0, 64'h0102_0304_0506_0708, 64'h1111_1111_1111_1111, '0);
    ar = addResult; af = addFlags;
    runOp("R11 mul after add", 2, 1, 64'h0003_0005_0007_0009, 64'h0002_0002_0002_0002, '0);
    check("R11 addResult held across mul", addResult, ar);
    check("R11 addFlags held across mul", W'(addFlags), W'(af));
    mr = mulResult;
    repeat (3) @(negedge clk);
    check("R11 idle addValid", W'(addValid), '0);
    check("R11 idle mulValid", W'(mulValid), '0);
    check("R11 idle addResult", addResult, ar);
    check("R11 idle mulResult", mulResult, mr);
  endtask

  task automatic testOverlap();
    logic [NB-1:0] ef, dummy;
    logic [W-1:0] em, ea;
    em = refRes(2, 0, 64'h0203_0405_0607_0809, 64'h0303_0303_0303_0303, '0, dummy);
    ea = refRes(0, 1, 64'hFFFF_0001_7FFF_8000, 64'h0001_FFFF_0001_8000, '0, ef);
    @(negedge clk);
    inValid = 1'b1; opcode = 2'd2; sizeCode = 2'd0;
    opA = 64'h0203_0405_0607_0809; opB = 64'h0303_0303_0303_0303; acc = '0;
    @(negedge clk);
    opcode = 2'd0; sizeCode = 2'd1;
    opA = 64'hFFFF_0001_7FFF_8000; opB = 64'h0001_FFFF_0001_8000;
    @(negedge clk);
    inValid = 1'b0;
    check("R13 addValid", W'(addValid), W'(1));
    check("R13 mulValid", W'(mulValid), W'(1));
    check("R13 addResult", addResult, ea);
    check("R13 addFlags", W'(addFlags), W'(ef));
    check("R13 mulResult", mulResult, em);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAdds();
    testSubs();
    testMuls();
    testMacs();
    testWide();
    testHold();
    testOverlap();
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule